// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block decides what the host sees on the read data path while an internally timed program or erase operation runs. A one-cycle start pulse launches the operation and selects its type. The block latches the byte being programmed and runs a down-counter. The counter's length is set by parameters, one for program and one for erase. The counter drives a busy flag.

While busy is high, reads return a status byte instead of array contents, so the host can detect completion in two ways:

- **Inverted bit 7.** Bit 7 holds the inverse of what the finished location will contain.
- **Toggling bit 6.** Bit 6 changes value on every read the host makes.

The host may start polling at any point in the operation, with no setup step. Once the counter expires, busy drops and reads pass the array data through unchanged.

An active-low reset aborts any running operation and returns the block to read mode. While reset is held low, the output enable is deasserted, which stands for a high-impedance data bus.

Top module: `op_status_rpt`

## Requirements
- R1: An accepted start pulse, taken while not busy, raises busy_o in the next cycle. busy_o then stays high for exactly PROG_CYCLES cycles when op_erase_i was 0, or ERASE_CYCLES cycles when it was 1.
- R2: A start pulse that arrives while busy_o is high has no effect. The busy duration, the operation type and the latched byte are all unchanged.
- R3: While a program operation is busy, rd_data_o[7] equals the inverse of bit 7 of the byte loaded with the start pulse.
- R4: While an erase operation is busy, rd_data_o[7] reads 0, the inverse of the erased value 1.
- R5: While busy, rd_data_o[6] changes value after every cycle in which rd_stb_i is high. It holds its value in cycles without a read strobe.
- R6: While busy, rd_data_o[5:0] read as 0.
- R7: While not busy and out of reset, rd_data_o equals arr_data_i in the same cycle.
- R8: While rst_n is low, the following hold: busy_o is 0, rd_oe_o is 0, and rd_data_o is 0. Any operation in progress is abandoned, and after release the block is in read mode.
- R9: The first cycle of every operation shows rd_data_o[6] = 0, whatever reads took place during earlier operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts the operation |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_erase_i | input | 1 | Operation type sampled with start: 1 = erase, 0 = program |
| load_data_i | input | 8 | Byte to be programmed, sampled with start |
| arr_data_i | input | 8 | Array read data for the current address |
| rd_stb_i | input | 1 | Host read strobe, one per read cycle |
| busy_o | output | 1 | Operation in progress |
| rd_oe_o | output | 1 | Read data output enable (low means high impedance) |
| rd_data_o | output | 8 | Data returned to the host |

## Verification
The bench drives a start pulse in the last busy cycle. A design that compares against the wrong counter value would accept that pulse and stretch or restart the operation. It also checks bit 6 on the first busy cycle after an operation that ended with an odd number of reads. A toggle that is not cleared would make that first read return 1. Reset is pulsed in the middle of an operation. A design with a synchronous reset or a missing enable gate would keep busy high or drive data while reset is low. Random read and start patterns run against a cycle model and catch off-by-one errors in busy length and toggles missed when strobes come back to back.

// File: rtl/op_status_rpt.sv
module op_status_rpt #(
  parameter int PROG_CYCLES  = 40,
  parameter int ERASE_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       op_erase_i,
  input  logic [7:0] load_data_i,
  input  logic [7:0] arr_data_i,
  input  logic       rd_stb_i,
  output logic       busy_o,
  output logic       rd_oe_o,
  output logic [7:0] rd_data_o
);

  localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYCLES - 1);

  logic             busy_q;
  logic             op_q;
  logic [7:0]       ld_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tog_q;

  wire accept = start_i && !busy_q;
  wire expire = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= 1'b0;
      ld_q   <= '0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      op_q   <= op_erase_i;
      ld_q   <= load_data_i;
      cnt_q  <= op_erase_i ? ERASE_LD : PROG_LD;
    end else if (expire) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tog_q <= 1'b0;
    else if (!busy_q || expire) tog_q <= 1'b0;
    else if (rd_stb_i)          tog_q <= ~tog_q;
  end

  wire       stat7  = op_q ? 1'b0 : ~ld_q[7];
  wire [7:0] status = {stat7, tog_q, 6'b0};

  assign busy_o    = busy_q;
  assign rd_oe_o   = rst_n;
  assign rd_data_o = !rst_n ? 8'h00 : (busy_q ? status : arr_data_i);

endmodule

// File: rtl/op_status_chk.sv
module op_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       rd_stb_i,
  input logic [7:0] arr_data_i,
  input logic       busy_o,
  input logic       rd_oe_o,
  input logic [7:0] rd_data_o,
  input logic       op_q,
  input logic [7:0] ld_q
);

  p_start_raises_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> ($stable(ld_q) && $stable(op_q)));

  p_prog_bit7_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !op_q) |-> (rd_data_o[7] == ~ld_q[7]));

  p_erase_bit7_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && op_q) |-> (rd_data_o[7] == 1'b0));

  p_toggle_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && rd_stb_i) |=> (!busy_o || (rd_data_o[6] != $past(rd_data_o[6]))));

  p_toggle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !rd_stb_i) |=> (!busy_o || $stable(rd_data_o[6])));

  p_low_bits_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (rd_data_o[5:0] == 6'b0));

  p_idle_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (rd_data_o == arr_data_i));

  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_n |-> (!rd_oe_o && !busy_o && rd_data_o == 8'h00));

  p_first_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (rd_data_o[6] == 1'b0));

endmodule

bind op_status_rpt op_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_stb_i(rd_stb_i),
  .arr_data_i(arr_data_i), .busy_o(busy_o), .rd_oe_o(rd_oe_o),
  .rd_data_o(rd_data_o), .op_q(op_q), .ld_q(ld_q)
);

// File: tb/tb_op_status_rpt.sv
module tb_op_status_rpt;
  localparam int PC = 12;
  localparam int EC = 30;

  logic clk = 0;
  logic rst_n = 0;
  logic start_i = 0, op_erase_i = 0, rd_stb_i = 0;
  logic [7:0] load_data_i = 0, arr_data_i = 0;
  logic busy_o, rd_oe_o;
  logic [7:0] rd_data_o;

  int compared = 0, mismatched = 0;
  bit done = 0;

  bit m_busy, m_erase, m_tog;
  int m_cnt;
  logic [7:0] m_d;

  op_status_rpt #(.PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut (.*);

  always #5 clk = ~clk;

  function automatic logic [7:0] exp_data(logic [7:0] arr);
    if (!m_busy) return arr;
    return {(m_erase ? 1'b0 : ~m_d[7]), m_tog, 6'b0};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(bit st, bit er, logic [7:0] ld, logic [7:0] arr, bit rd);
    logic [7:0] e;
    @(negedge clk);
    start_i = st; op_erase_i = er; load_data_i = ld; arr_data_i = arr; rd_stb_i = rd;
    #1;
    chk(st && m_busy ? "R2 busy" : "R1 busy", {7'b0, busy_o}, {7'b0, m_busy});
    e = exp_data(arr);
    if (!m_busy) chk("R7 idle data", rd_data_o, e);
    else begin
      chk(m_erase ? "R4 bit7" : "R3 bit7", {7'b0, rd_data_o[7]}, {7'b0, e[7]});
      chk(m_cnt == (m_erase ? EC : PC) ? "R9 first bit6" : "R5 bit6",
          {7'b0, rd_data_o[6]}, {7'b0, e[6]});
      chk("R6 low bits", {2'b0, rd_data_o[5:0]}, 8'h00);
    end
    if (m_busy) begin
      if (rd) m_tog = ~m_tog;
      m_cnt--;
      if (m_cnt == 0) begin m_busy = 0; m_tog = 0; end
    end else if (st) begin
      m_busy = 1; m_erase = er; m_d = ld; m_cnt = er ? EC : PC; m_tog = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; start_i = 0; rd_stb_i = 0;
    #1;
    chk("R8 oe", {7'b0, rd_oe_o}, 8'h00);
    chk("R8 busy", {7'b0, busy_o}, 8'h00);
    chk("R8 data", rd_data_o, 8'h00);
    m_busy = 0; m_tog = 0;
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk("R8 reset oe", {7'b0, rd_oe_o}, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R7 idle pass-through
    cyc(0, 0, 8'h00, 8'hA5, 1);
    cyc(0, 0, 8'h00, 8'h3C, 0);
    // R3 program with bit7 = 1, odd number of reads
    cyc(1, 0, 8'h80, 8'hFF, 0);
    for (int i = 0; i < PC; i++) cyc(0, 0, 8'h00, 8'hFF, (i < 5));
    // R9 new program right after, bit7 = 0; R2 start in last busy cycle
    cyc(1, 0, 8'h15, 8'h11, 1);
    for (int i = 0; i < PC - 1; i++) cyc(0, 0, 8'h00, 8'h22, 1);
    cyc(1, 1, 8'hFF, 8'h33, 1);
    cyc(0, 0, 8'h00, 8'h44, 0);
    // R4 erase with start attempts while busy (R2)
    cyc(1, 1, 8'h00, 8'h00, 0);
    for (int i = 0; i < EC; i++) cyc((i % 7) == 3, 0, 8'h7F, 8'h5A, (i % 3) != 0);
    cyc(0, 0, 8'h00, 8'hC3, 1);
    // R8 abort mid-operation
    cyc(1, 1, 8'h00, 8'h00, 1);
    for (int i = 0; i < 5; i++) cyc(0, 0, 8'h00, 8'h00, 1);
    do_reset();
    cyc(0, 0, 8'h00, 8'h96, 1);
    cyc(1, 0, 8'h01, 8'h00, 1);
    for (int i = 0; i < 3; i++) cyc(0, 0, 8'h00, 8'h00, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (i % 1000 == 999) do_reset();
      cyc(($urandom % 12) == 0, $urandom % 2, 8'($urandom), 8'($urandom), $urandom % 2);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule